// File: doc/BRIEF.md
# Multichannel Packet Bus Protocol Monitor

This block sits beside a wide, channelized packet transmit bus and watches it without touching it. The bus carries packets for up to 256 interleaved channels. In each cycle an enable qualifies a start marker, an end marker, a channel number, an empty-lane count and an error bit. The monitor keeps an open or closed state for every channel. It checks that starts and ends on each channel alternate correctly, and it raises sticky violation flags when they do not. Software or a test environment can then read those flags and clear them with a pulse.

For every packet that ends legally, the monitor reports the channel, the byte length and the bad-packet marking for one cycle after the closing beat. It also adds the packet into per-channel tallies of packets, bad packets and bytes, which can be read through a combinational query port. The data bus itself plays no part in any check, so it is not an input.

Top module: `pkt_bus_monitor`

## Requirements
- R1: While and after reset is high, every channel is closed, all three flags are low, done_valid is low and every per-channel counter reads zero.
- R2: In a cycle with en_in low, no input has any effect: no channel opens or closes, no flag sets, no completion is reported and no counter changes.
- R3: An enabled start opens the given channel and an enabled end closes it. Start and end together form a one-beat packet that leaves the channel closed. Channels keep their state independently, so beats of different channels may interleave.
- R4: An enabled start on a channel that is already open sets flag_dup_sop from the next cycle. The packet on that channel restarts its length count from that beat.
- R5: An enabled beat without a start on a closed channel sets flag_orphan from the next cycle. This covers both a data beat and an end beat. Such a beat produces no completion and changes no counter.
- R6: One cycle after an enabled end on an open channel, or after an enabled start-plus-end, done_valid is high for exactly one cycle. In that cycle done_chan holds the channel and done_bad holds the error input of the end beat. done_len holds 64 bytes for every beat before the last plus 64 minus the empty count for the last beat. The empty count N (6 bits) means that the N least significant byte lanes are unused.
- R7: The empty count and the error input are used only in cycles where en_in and eop_in are both high. A nonzero empty count in an enabled cycle without an end sets flag_mty_warn from the next cycle.
- R8: Each completed packet adds 1 to its channel's packet count and its length to that channel's byte count. If its error input was high, it also adds 1 to that channel's bad count. The counts of the channel on q_chan appear combinationally on q_pkts, q_bad and q_bytes.
- R9: Each flag stays high until a cycle with clr_flags high and no new violation of that kind. If a violation occurs in the same cycle as the clear, the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Qualifies all other bus inputs |
| sop_in | input | 1 | Start-of-packet marker |
| eop_in | input | 1 | End-of-packet marker |
| chan_in | input | 8 | Channel of the current beat |
| mty_in | input | 6 | Unused byte lanes on the last beat, counted from the least significant byte |
| err_in | input | 1 | Marks the packet bad on its end beat |
| clr_flags | input | 1 | Synchronous clear pulse for the sticky flags |
| q_chan | input | 8 | Channel selected for counter readout |
| flag_dup_sop | output | 1 | Sticky: start seen on an already open channel |
| flag_orphan | output | 1 | Sticky: beat without start on a closed channel |
| flag_mty_warn | output | 1 | Sticky: nonzero empty count without end |
| done_valid | output | 1 | One-cycle completion strobe |
| done_chan | output | 8 | Channel of the completed packet |
| done_len | output | 16 | Byte length of the completed packet |
| done_bad | output | 1 | Completed packet was marked bad |
| q_pkts | output | 32 | Packet count of channel q_chan |
| q_bad | output | 32 | Bad-packet count of channel q_chan |
| q_bytes | output | 40 | Byte count of channel q_chan |

## Verification
The length path is tried with one-beat packets, two-beat packets on channels whose beats interleave, and a three-beat packet, using empty counts of 0, 10 and 63. This separates a correct per-channel running sum from a sum shared across channels, and it exposes an error in the lane arithmetic. A disabled beat that carries start, end, error and a nonzero empty count shows whether the qualifier is obeyed. An enabled start followed by a second start on the same channel tells the qualifier bug apart from duplicate-start detection. Orphan beats, a clear issued together with a new violation, and the counters read back per channel show apart the sticky-flag priority and which counter belongs to which channel.

// File: rtl/pktmon_pkg.sv
package pktmon_pkg;

   // One bit per rule the monitor enforces.
   typedef struct packed {
      logic mty_warn;   // empty count given without end
      logic orphan;     // beat on closed channel without start
      logic dup_sop;    // start on channel already open
   } viol_t;

   localparam int VIOL_N = $bits(viol_t);

   function automatic logic [31:0] pow2(input int unsigned w);
      return 32'(1) << w;
   endfunction

endpackage

// File: rtl/pktmon_chan_track.sv
module pktmon_chan_track #(
   parameter int CHAN_W = 8,
   parameter int MTY_W  = 6,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              sop,
   input  logic              eop,
   input  logic [CHAN_W-1:0] chan,
   input  logic [MTY_W-1:0]  mty,
   output logic              cur_open,
   output logic [LEN_W-1:0]  pkt_len,
   output logic              fire
);
   localparam int NCH   = 1 << CHAN_W;
   localparam int BYTES = 1 << MTY_W;

   logic [NCH-1:0]   open_q;
   logic [LEN_W-1:0] len_q [NCH];
   logic [LEN_W-1:0] base;
   logic [LEN_W-1:0] beat;

   always_comb begin
      cur_open = open_q[chan];
      base     = sop ? '0 : len_q[chan];
      beat     = eop ? (LEN_W'(BYTES) - LEN_W'(mty)) : LEN_W'(BYTES);
      pkt_len  = base + beat;
      fire     = en & eop & (sop | cur_open);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         open_q <= '0;
         for (int i = 0; i < NCH; i++) len_q[i] <= '0;
      end else if (en) begin
         if (eop) begin
            open_q[chan] <= 1'b0;
            len_q[chan]  <= '0;
         end else if (sop) begin
            open_q[chan] <= 1'b1;
            len_q[chan]  <= pkt_len;
         end else if (cur_open) begin
            len_q[chan]  <= pkt_len;
         end
      end
   end
endmodule

// File: rtl/pktmon_rules.sv
module pktmon_rules
   import pktmon_pkg::*;
#(
   parameter int MTY_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             sop,
   input  logic             eop,
   input  logic [MTY_W-1:0] mty,
   input  logic             cur_open,
   input  logic             clr,
   output viol_t            flags
);
   viol_t             hit;
   logic [VIOL_N-1:0] hit_v;
   logic [VIOL_N-1:0] flag_v;

   always_comb begin
      hit.dup_sop  = en & sop & cur_open;
      hit.orphan   = en & ~sop & ~cur_open;
      hit.mty_warn = en & ~eop & (mty != '0);
      hit_v        = hit;
   end

   for (genvar k = 0; k < VIOL_N; k++) begin : g_flag
      always_ff @(posedge clk) begin
         if (rst)           flag_v[k] <= 1'b0;
         else if (hit_v[k]) flag_v[k] <= 1'b1;
         else if (clr)      flag_v[k] <= 1'b0;
      end
   end

   assign flags = viol_t'(flag_v);
endmodule

// File: rtl/pktmon_stats.sv
module pktmon_stats #(
   parameter int CHAN_W    = 8,
   parameter int LEN_W     = 16,
   parameter int PKT_W     = 32,
   parameter int BYTE_W    = 40,
   parameter bit COUNT_BAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic [CHAN_W-1:0] chan,
   input  logic [LEN_W-1:0]  len,
   input  logic              bad,
   input  logic [CHAN_W-1:0] q_chan,
   output logic [PKT_W-1:0]  q_pkts,
   output logic [PKT_W-1:0]  q_bad,
   output logic [BYTE_W-1:0] q_bytes
);
   localparam int NCH = 1 << CHAN_W;

   logic [PKT_W-1:0]  pkts_q  [NCH];
   logic [BYTE_W-1:0] bytes_q [NCH];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NCH; i++) begin
            pkts_q[i]  <= '0;
            bytes_q[i] <= '0;
         end
      end else if (fire) begin
         pkts_q[chan]  <= pkts_q[chan] + PKT_W'(1);
         bytes_q[chan] <= bytes_q[chan] + BYTE_W'(len);
      end
   end

   assign q_pkts  = pkts_q[q_chan];
   assign q_bytes = bytes_q[q_chan];

   if (COUNT_BAD) begin : g_bad
      logic [PKT_W-1:0] bad_q [NCH];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int i = 0; i < NCH; i++) bad_q[i] <= '0;
         end else if (fire && bad) begin
            bad_q[chan] <= bad_q[chan] + PKT_W'(1);
         end
      end
      assign q_bad = bad_q[q_chan];
   end else begin : g_nobad
      assign q_bad = '0;
   end
endmodule

// File: rtl/pkt_bus_monitor.sv
module pkt_bus_monitor
   import pktmon_pkg::*;
#(
   parameter int CHAN_W    = 8,
   parameter int MTY_W     = 6,
   parameter int LEN_W     = 16,
   parameter int PKT_W     = 32,
   parameter int BYTE_W    = 40,
   parameter bit COUNT_BAD = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en_in,
   input  logic              sop_in,
   input  logic              eop_in,
   input  logic [CHAN_W-1:0] chan_in,
   input  logic [MTY_W-1:0]  mty_in,
   input  logic              err_in,
   input  logic              clr_flags,
   input  logic [CHAN_W-1:0] q_chan,
   output logic              flag_dup_sop,
   output logic              flag_orphan,
   output logic              flag_mty_warn,
   output logic              done_valid,
   output logic [CHAN_W-1:0] done_chan,
   output logic [LEN_W-1:0]  done_len,
   output logic              done_bad,
   output logic [PKT_W-1:0]  q_pkts,
   output logic [PKT_W-1:0]  q_bad,
   output logic [BYTE_W-1:0] q_bytes
);
   localparam int BYTES = int'(pow2(MTY_W));

   if (CHAN_W < 1 || CHAN_W > 10) begin : g_chk_chan
      $error("CHAN_W out of supported range");
   end
   if (LEN_W <= MTY_W) begin : g_chk_len
      $error("LEN_W must exceed MTY_W");
   end
   if (BYTE_W < LEN_W) begin : g_chk_byte
      $error("BYTE_W must be at least LEN_W");
   end

   logic             cur_open;
   logic [LEN_W-1:0] pkt_len;
   logic             fire;
   viol_t            flags;

   pktmon_chan_track #(.CHAN_W(CHAN_W), .MTY_W(MTY_W), .LEN_W(LEN_W)) track_i (
      .clk(clk), .rst(rst), .en(en_in), .sop(sop_in), .eop(eop_in),
      .chan(chan_in), .mty(mty_in),
      .cur_open(cur_open), .pkt_len(pkt_len), .fire(fire)
   );

   pktmon_rules #(.MTY_W(MTY_W)) rules_i (
      .clk(clk), .rst(rst), .en(en_in), .sop(sop_in), .eop(eop_in),
      .mty(mty_in), .cur_open(cur_open), .clr(clr_flags), .flags(flags)
   );

   pktmon_stats #(.CHAN_W(CHAN_W), .LEN_W(LEN_W), .PKT_W(PKT_W),
                  .BYTE_W(BYTE_W), .COUNT_BAD(COUNT_BAD)) stats_i (
      .clk(clk), .rst(rst), .fire(fire), .chan(chan_in), .len(pkt_len),
      .bad(err_in), .q_chan(q_chan),
      .q_pkts(q_pkts), .q_bad(q_bad), .q_bytes(q_bytes)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done_valid <= 1'b0;
         done_chan  <= '0;
         done_len   <= '0;
         done_bad   <= 1'b0;
      end else begin
         done_valid <= fire;
         if (fire) begin
            done_chan <= chan_in;
            done_len  <= pkt_len;
            done_bad  <= err_in;
         end
      end
   end

   assign flag_dup_sop  = flags.dup_sop;
   assign flag_orphan   = flags.orphan;
   assign flag_mty_warn = flags.mty_warn;

   localparam int UNUSED_BYTES = BYTES;
endmodule

// File: rtl/pkt_bus_monitor_chk.sv
module pkt_bus_monitor_chk #(
   parameter int CHAN_W = 8,
   parameter int MTY_W  = 6,
   parameter int LEN_W  = 16
) (
   input logic              clk,
   input logic              rst,
   input logic              en_in,
   input logic              sop_in,
   input logic              eop_in,
   input logic [CHAN_W-1:0] chan_in,
   input logic [MTY_W-1:0]  mty_in,
   input logic              err_in,
   input logic              clr_flags,
   input logic              flag_dup_sop,
   input logic              flag_orphan,
   input logic              flag_mty_warn,
   input logic              done_valid,
   input logic [CHAN_W-1:0] done_chan,
   input logic [LEN_W-1:0]  done_len,
   input logic              done_bad
);
   localparam int BYTES = 1 << MTY_W;

   // R6: a completion only follows an enabled end beat
   a_r6_done_after_eop: assert property (@(posedge clk) disable iff (rst)
      done_valid |-> $past(en_in && eop_in));

   // R6: completion carries the channel and error bit of the end beat
   a_r6_done_fields: assert property (@(posedge clk) disable iff (rst)
      done_valid |-> (done_chan == $past(chan_in)) && (done_bad == $past(err_in)));

   // R3, R6: one-beat packet length is the bus width less the empty lanes
   a_r3_single_beat_len: assert property (@(posedge clk) disable iff (rst)
      (en_in && sop_in && eop_in) |=>
         (done_valid && done_len == LEN_W'(BYTES) - LEN_W'($past(mty_in))));

   // R7: empty count without end raises the warning flag
   a_r7_mty_warn_set: assert property (@(posedge clk) disable iff (rst)
      (en_in && !eop_in && mty_in != '0) |=> flag_mty_warn);

   // R9: flags hold while no clear is given
   a_r9_dup_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_dup_sop && !clr_flags) |=> flag_dup_sop);
   a_r9_orphan_sticky: assert property (@(posedge clk) disable iff (rst)
      (flag_orphan && !clr_flags) |=> flag_orphan);

   // R9: clear with no new warning drops the warning flag
   a_r9_warn_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_flags && !(en_in && !eop_in && mty_in != '0)) |=> !flag_mty_warn);

   // R2: disabled cycles create no completion
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !en_in |=> !done_valid);
endmodule

bind pkt_bus_monitor pkt_bus_monitor_chk #(
   .CHAN_W(CHAN_W), .MTY_W(MTY_W), .LEN_W(LEN_W)
) chk_i (
   .clk(clk), .rst(rst), .en_in(en_in), .sop_in(sop_in), .eop_in(eop_in),
   .chan_in(chan_in), .mty_in(mty_in), .err_in(err_in), .clr_flags(clr_flags),
   .flag_dup_sop(flag_dup_sop), .flag_orphan(flag_orphan),
   .flag_mty_warn(flag_mty_warn), .done_valid(done_valid),
   .done_chan(done_chan), .done_len(done_len), .done_bad(done_bad)
);

// File: tb/pkt_bus_monitor_tb_top.sv
`timescale 1ns/1ps
module pkt_bus_monitor_tb_top;
   logic        clk = 1'b0;
   logic        rst, en_in, sop_in, eop_in, err_in, clr_flags;
   logic [7:0]  chan_in, q_chan, done_chan;
   logic [5:0]  mty_in;
   logic        flag_dup_sop, flag_orphan, flag_mty_warn, done_valid, done_bad;
   logic [15:0] done_len;
   logic [31:0] q_pkts, q_bad;
   logic [39:0] q_bytes;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   pkt_bus_monitor dut_i (
      .clk(clk), .rst(rst), .en_in(en_in), .sop_in(sop_in), .eop_in(eop_in),
      .chan_in(chan_in), .mty_in(mty_in), .err_in(err_in), .clr_flags(clr_flags),
      .q_chan(q_chan), .flag_dup_sop(flag_dup_sop), .flag_orphan(flag_orphan),
      .flag_mty_warn(flag_mty_warn), .done_valid(done_valid), .done_chan(done_chan),
      .done_len(done_len), .done_bad(done_bad), .q_pkts(q_pkts), .q_bad(q_bad),
      .q_bytes(q_bytes)
   );

   // en sop eop chan mty err | exp_done exp_len exp_bad
   typedef struct packed {
      logic en; logic sop; logic eop; logic [7:0] ch; logic [5:0] mty; logic err;
      logic xd; logic [15:0] xlen; logic xbad;
   } vec_t;

   localparam int NV = 9;
   localparam vec_t VEC [NV] = '{
      '{1'b1,1'b1,1'b1,8'd5,6'd0, 1'b0, 1'b1,16'd64, 1'b0},  // R3 one-beat
      '{1'b1,1'b1,1'b0,8'd1,6'd0, 1'b0, 1'b0,16'd0,  1'b0},  // R3 open ch1
      '{1'b1,1'b1,1'b0,8'd2,6'd0, 1'b0, 1'b0,16'd0,  1'b0},  // R3 open ch2
      '{1'b1,1'b0,1'b0,8'd1,6'd0, 1'b0, 1'b0,16'd0,  1'b0},  // R3 interleave
      '{1'b1,1'b0,1'b1,8'd2,6'd10,1'b1, 1'b1,16'd118,1'b1},  // R6 bad end ch2
      '{1'b0,1'b1,1'b1,8'd1,6'd3, 1'b1, 1'b0,16'd0,  1'b0},  // R2 disabled
      '{1'b1,1'b0,1'b1,8'd1,6'd63,1'b0, 1'b1,16'd129,1'b0},  // R6 mty 63
      '{1'b1,1'b1,1'b0,8'd3,6'd5, 1'b0, 1'b0,16'd0,  1'b0},  // R7 warn
      '{1'b1,1'b0,1'b1,8'd3,6'd0, 1'b0, 1'b1,16'd128,1'b0}   // R7 mty ignored
   };

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic beat(input logic e, input logic s, input logic x, input logic [7:0] c,
                       input logic [5:0] m, input logic er, input logic cl);
      @(negedge clk);
      en_in = e; sop_in = s; eop_in = x; chan_in = c; mty_in = m; err_in = er;
      clr_flags = cl;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      beat(1'b0, 1'b0, 1'b0, 8'd0, 6'd0, 1'b0, 1'b0);
   endtask

   task automatic read_cnt(input logic [7:0] c, input string req,
                           input longint p, input longint b, input longint by);
      q_chan = c;
      #0.5;
      chk({req, " pkts"}, q_pkts, p);
      chk({req, " bad"}, q_bad, b);
      chk({req, " bytes"}, q_bytes, by);
   endtask

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst = 1'b1; en_in = 0; sop_in = 0; eop_in = 0; chan_in = 0; mty_in = 0;
      err_in = 0; clr_flags = 0; q_chan = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 dup", flag_dup_sop, 0);
      chk("R1 orphan", flag_orphan, 0);
      chk("R1 warn", flag_mty_warn, 0);
      chk("R1 done", done_valid, 0);
      read_cnt(8'd5, "R1", 0, 0, 0);
      @(negedge clk); rst = 1'b0;

      // table walk: completion after each beat
      for (int i = 0; i < NV; i++) begin
         beat(VEC[i].en, VEC[i].sop, VEC[i].eop, VEC[i].ch, VEC[i].mty, VEC[i].err, 1'b0);
         chk("R6 done_valid", done_valid, VEC[i].xd);
         if (VEC[i].xd) begin
            chk("R6 done_len", done_len, VEC[i].xlen);
            chk("R6 done_bad", done_bad, VEC[i].xbad);
            chk("R6 done_chan", done_chan, VEC[i].ch);
         end
      end
      idle();
      chk("R6 one-cycle strobe", done_valid, 0);
      chk("R4 no dup yet", flag_dup_sop, 0);
      chk("R5 no orphan yet", flag_orphan, 0);
      chk("R7 warn set", flag_mty_warn, 1);
      read_cnt(8'd1, "R8 ch1", 1, 0, 129);
      read_cnt(8'd2, "R8 ch2", 1, 1, 118);
      read_cnt(8'd5, "R8 ch5", 1, 0, 64);
      read_cnt(8'd0, "R8 ch0", 0, 0, 0);

      // R9 clear
      beat(1'b0, 1'b0, 1'b0, 8'd0, 6'd0, 1'b0, 1'b1);
      chk("R9 warn cleared", flag_mty_warn, 0);

      // R2: disabled start must not open ch7, nor set flags
      beat(1'b0, 1'b1, 1'b0, 8'd7, 6'd9, 1'b0, 1'b0);
      chk("R2 no warn when disabled", flag_mty_warn, 0);
      beat(1'b1, 1'b1, 1'b0, 8'd7, 6'd0, 1'b0, 1'b0);
      chk("R2 disabled start did not open", flag_dup_sop, 0);
      // R4 duplicate start restarts length
      beat(1'b1, 1'b1, 1'b0, 8'd7, 6'd0, 1'b0, 1'b0);
      chk("R4 dup flag", flag_dup_sop, 1);
      beat(1'b1, 1'b0, 1'b1, 8'd7, 6'd0, 1'b0, 1'b0);
      chk("R4 restarted len", done_len, 128);

      // R5 orphan end on closed channel
      beat(1'b1, 1'b0, 1'b1, 8'd9, 6'd0, 1'b0, 1'b0);
      chk("R5 orphan flag", flag_orphan, 1);
      chk("R5 no completion", done_valid, 0);
      read_cnt(8'd9, "R5 ch9", 0, 0, 0);

      // R9 clear with concurrent orphan data beat keeps flag
      beat(1'b1, 1'b0, 1'b0, 8'd9, 6'd0, 1'b0, 1'b1);
      chk("R9 set wins over clear", flag_orphan, 1);
      chk("R9 dup cleared", flag_dup_sop, 0);
      beat(1'b0, 1'b0, 1'b0, 8'd0, 6'd0, 1'b0, 1'b1);
      chk("R9 orphan cleared", flag_orphan, 0);

      // R3 three-beat packet then closed
      beat(1'b1, 1'b1, 1'b0, 8'd200, 6'd0, 1'b0, 1'b0);
      beat(1'b1, 1'b0, 1'b0, 8'd200, 6'd0, 1'b0, 1'b0);
      beat(1'b1, 1'b0, 1'b1, 8'd200, 6'd1, 1'b0, 1'b0);
      chk("R3 three-beat len", done_len, 191);
      beat(1'b1, 1'b0, 1'b0, 8'd200, 6'd0, 1'b0, 1'b0);
      chk("R3 closed after end", flag_orphan, 1);

      // R1 reset mid-run clears counters and flags
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      chk("R1 orphan after reset", flag_orphan, 0);
      read_cnt(8'd1, "R1 ch1", 0, 0, 0);
      @(negedge clk); rst = 1'b0;

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule